// File: doc/BRIEF.md
# Relocatable Register Window Decoder

This block decodes accesses to a 2 MB window of on-chip registers inside a 36-bit byte address space. The upper fifteen address bits of each request are compared against a programmable base register. On a match, the low 21 bits select a register inside the window. The base register is itself one of the registers in the window, so writing it moves the whole window to a new location. Later accesses must then use the new base.

Inside the window, each offset belongs to a register group taken from a range table. Most groups treat byte enables coarsely: any enabled lane writes the full 32-bit word. The bus-bridge and interrupt groups honour each byte lane on its own. Offsets that fall in no group read as zero and drop writes. A request with no byte lane enabled never writes anything. Configuration registers are not mapped directly. They are reached through an address register and a data port: the data port forwards each access to the configuration bank at the offset held in the address register.

The block keeps the base register and the configuration address register. Every other register lives behind a side port. That port carries a select strobe, the direction, a space flag, a dword offset, the write data and a per-lane write mask, and it returns read data in the same cycle. Reads finish one cycle later with a one-cycle valid pulse.

Top module: `regwin_decoder`

## Requirements
- R1: A request hits the window only when req_addr[35:21] equals the current base value. A request that misses raises neither rf_sel nor, one cycle later, rd_valid.
- R2: After reset the base value is 0x0A0, so window offset 0x800 answers at byte address 0x14000800. A read there appears on the side port as dword offset 0x200.
- R3: The base register sits at window offset 0x068 and reads back as {17'b0, base}. A write there with any lane enabled loads req_wdata[14:0]. The new base applies from the next request on: the write itself completes at the old address, and the old address then misses. This register never appears on the side port.
- R4: A write with req_be_n equal to 4'hF changes no register and raises no rf_sel, whatever the source tag.
- R5: The full-word groups are 0x000–0x0FF, 0x100–0x3FF, 0x400–0x7FF, 0x800–0x9FF, 0xA00–0xBFF and 0xD00–0xDFF. A write there with at least one lane enabled drives rf_byte_en = 4'b1111.
- R6: The lane-sensitive groups are 0xC00–0xCFF and 0xE00–0xEFF. A write there drives rf_byte_en = ~req_be_n, where bit i enables data bits [8i+7:8i].
- R7: Window offsets in no group (0xF00 and above) raise no rf_sel, read as zero, and ignore writes.
- R8: The configuration address register sits at offset 0xCF8 and resets to zero. It is lane-sensitive, it holds bits [7:2] of the written value, and bits [1:0] always read as zero. It never appears on the side port.
- R9: An access to offset 0xCFC raises rf_sel with rf_cfg = 1 and rf_offset = the configuration address divided by four. Writes use the lane-sensitive mask. A read returns rf_rdata, so with 0x004 held the read reaches configuration dword 1.
- R10: Every read that hits the window, whether mapped or not, produces rd_valid high for exactly the next cycle, with rd_data holding the value selected for that read.
- R11: Direct side-port accesses carry rf_cfg = 0, rf_offset = req_addr[20:2], rf_wdata = req_wdata and rf_src = req_src in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 36 | Byte address |
| req_wdata | input | 32 | Write data |
| req_be_n | input | 4 | Active-low byte lane enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_src | input | 1 | Source tag (0 = processor, 1 = bus bridge) |
| rd_valid | output | 1 | Read result valid (one-cycle pulse) |
| rd_data | output | 32 | Read result |
| rf_sel | output | 1 | Side-port access strobe |
| rf_write | output | 1 | Side-port direction |
| rf_cfg | output | 1 | 1 = configuration bank, 0 = register file |
| rf_offset | output | 19 | Dword offset within the selected space |
| rf_wdata | output | 32 | Side-port write data |
| rf_byte_en | output | 4 | Active-high per-lane write mask |
| rf_src | output | 1 | Source tag of the access |
| rf_rdata | input | 32 | Side-port read data, same cycle |

## Verification
The bench builds the block with its defaults: a 36-bit address, a 21-bit window and an 8-bit configuration offset. With these values every group boundary in the first 4 KB can be reached, along with the unmapped tail of the window. The bench sweeps all sixteen byte-enable patterns at every 64-byte step of that range, comparing each side-port mask against an arithmetic model of the group table. It then flips each base-compare bit in turn to confirm a miss. Finally it moves the window and exercises the configuration address/data pair at dword granularity.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [1:0] {
        GRP_NONE = 2'd0,
        GRP_FULL = 2'd1,
        GRP_LANE = 2'd2
    } grp_kind_e;

    typedef struct packed {
        logic [11:0] lo;
        logic [11:0] hi;
        grp_kind_e   kind;
    } grp_range_t;

    localparam int NUM_GRP = 8;
    localparam int LANES   = 4;

    // range table of register groups, non-overlapping
    function automatic grp_range_t grp_entry(input int idx);
        grp_range_t e;
        case (idx)
            0:       e = '{lo: 12'h000, hi: 12'h0FF, kind: GRP_FULL};
            1:       e = '{lo: 12'h100, hi: 12'h3FF, kind: GRP_FULL};
            2:       e = '{lo: 12'h400, hi: 12'h7FF, kind: GRP_FULL};
            3:       e = '{lo: 12'h800, hi: 12'h9FF, kind: GRP_FULL};
            4:       e = '{lo: 12'hA00, hi: 12'hBFF, kind: GRP_FULL};
            5:       e = '{lo: 12'hC00, hi: 12'hCFF, kind: GRP_LANE};
            6:       e = '{lo: 12'hD00, hi: 12'hDFF, kind: GRP_FULL};
            default: e = '{lo: 12'hE00, hi: 12'hEFF, kind: GRP_LANE};
        endcase
        return e;
    endfunction

    // active-high lane mask derived from group policy and active-low enables
    function automatic logic [LANES-1:0] lane_mask(input grp_kind_e kind,
                                                   input logic [LANES-1:0] be_n);
        logic [LANES-1:0] m;
        case (kind)
            GRP_FULL: m = (&be_n) ? '0 : '1;
            GRP_LANE: m = ~be_n;
            default:  m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [8*LANES-1:0] merge_lanes(input logic [8*LANES-1:0] old_v,
                                                       input logic [8*LANES-1:0] new_v,
                                                       input logic [LANES-1:0]   mask);
        logic [8*LANES-1:0] r;
        for (int i = 0; i < LANES; i++)
            r[8*i +: 8] = mask[i] ? new_v[8*i +: 8] : old_v[8*i +: 8];
        return r;
    endfunction

endpackage

// File: rtl/regwin_group_lookup.sv
module regwin_group_lookup
    import regwin_pkg::*;
#(
    parameter int OFF_W = 21
) (
    input  logic [OFF_W-1:0] offset,
    output grp_kind_e        kind
);
    localparam int TBL_W = 12;

    logic              high_zero;
    logic [NUM_GRP-1:0] match;

    assign high_zero = (offset[OFF_W-1:TBL_W] == '0);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_rng
        localparam grp_range_t ENT = grp_entry(g);
        assign match[g] = high_zero &&
                          (offset[TBL_W-1:0] >= ENT.lo) &&
                          (offset[TBL_W-1:0] <= ENT.hi);
    end

    always_comb begin
        kind = GRP_NONE;
        for (int g = 0; g < NUM_GRP; g++)
            if (match[g]) kind = grp_entry(g).kind;
    end

endmodule

// File: rtl/regwin_local_regs.sv
module regwin_local_regs
    import regwin_pkg::*;
#(
    parameter int             BASE_W     = 15,
    parameter int             CFG_W      = 8,
    parameter logic [BASE_W-1:0] BASE_RESET = 15'h0A0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 base_we,
    input  logic                 cfga_we,
    input  logic [8*LANES-1:0]   wdata,
    input  logic [LANES-1:0]     mask,
    output logic [BASE_W-1:0]    base_q,
    output logic [CFG_W-1:0]     cfga_q
);
    localparam int DW = 8 * LANES;

    logic [DW-1:0] base_ext, cfga_ext, base_new, cfga_new;

    assign base_ext = DW'(base_q);
    assign cfga_ext = DW'(cfga_q);
    assign base_new = merge_lanes(base_ext, wdata, mask);
    assign cfga_new = merge_lanes(cfga_ext, wdata, mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= BASE_RESET;
            cfga_q <= '0;
        end else begin
            if (base_we) base_q <= base_new[BASE_W-1:0];
            if (cfga_we) cfga_q <= {cfga_new[CFG_W-1:2], 2'b00};
        end
    end

    // R8
    cfga_align_chk: assert property (@(posedge clk) disable iff (rst)
        cfga_q[1:0] == 2'b00);

endmodule

// File: rtl/regwin_decoder.sv
module regwin_decoder
    import regwin_pkg::*;
#(
    parameter int                ADDR_W     = 36,
    parameter int                WIN_LSB    = 21,
    parameter int                CFG_W      = 8,
    parameter logic [ADDR_W-WIN_LSB-1:0] BASE_RESET = 15'h0A0,
    parameter logic [WIN_LSB-1:0] BASE_OFF  = 21'h068,
    parameter logic [WIN_LSB-1:0] CFGA_OFF  = 21'hCF8,
    parameter logic [WIN_LSB-1:0] CFGD_OFF  = 21'hCFC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [31:0]          req_wdata,
    input  logic [3:0]           req_be_n,
    input  logic                 req_write,
    input  logic                 req_src,
    output logic                 rd_valid,
    output logic [31:0]          rd_data,
    output logic                 rf_sel,
    output logic                 rf_write,
    output logic                 rf_cfg,
    output logic [WIN_LSB-3:0]   rf_offset,
    output logic [31:0]          rf_wdata,
    output logic [3:0]           rf_byte_en,
    output logic                 rf_src,
    input  logic [31:0]          rf_rdata
);
    localparam int BASE_W = ADDR_W - WIN_LSB;
    localparam int DW_W   = WIN_LSB - 2;

    logic [BASE_W-1:0]  base_q;
    logic [CFG_W-1:0]   cfga_q;
    logic [WIN_LSB-1:0] off_dw;
    grp_kind_e          kind;
    logic               hit, is_base, is_cfga, is_cfgd, any_lane;
    logic [3:0]         mask;
    logic [31:0]        rd_mux;

    assign hit     = req_valid && (req_addr[ADDR_W-1:WIN_LSB] == base_q);
    assign off_dw  = {req_addr[WIN_LSB-1:2], 2'b00};
    assign is_base = (off_dw == BASE_OFF);
    assign is_cfga = (off_dw == CFGA_OFF);
    assign is_cfgd = (off_dw == CFGD_OFF);

    regwin_group_lookup #(.OFF_W(WIN_LSB)) u_lookup (
        .offset (off_dw),
        .kind   (kind)
    );

    assign mask     = lane_mask(kind, req_be_n);
    assign any_lane = (mask != '0);

    regwin_local_regs #(
        .BASE_W     (BASE_W),
        .CFG_W      (CFG_W),
        .BASE_RESET (BASE_RESET)
    ) u_local (
        .clk     (clk),
        .rst     (rst),
        .base_we (hit && req_write && is_base && any_lane),
        .cfga_we (hit && req_write && is_cfga && any_lane),
        .wdata   (req_wdata),
        .mask    (mask),
        .base_q  (base_q),
        .cfga_q  (cfga_q)
    );

    // side port
    assign rf_sel     = hit && (kind != GRP_NONE) && !is_base && !is_cfga &&
                        (!req_write || any_lane);
    assign rf_write   = req_write;
    assign rf_cfg     = is_cfgd;
    assign rf_offset  = is_cfgd ? DW_W'(cfga_q[CFG_W-1:2]) : req_addr[WIN_LSB-1:2];
    assign rf_wdata   = req_wdata;
    assign rf_byte_en = mask;
    assign rf_src     = req_src;

    always_comb begin
        if (is_base)               rd_mux = 32'(base_q);
        else if (is_cfga)          rd_mux = 32'(cfga_q);
        else if (kind == GRP_NONE) rd_mux = '0;
        else                       rd_mux = rf_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= hit && !req_write;
            if (hit && !req_write) rd_data <= rd_mux;
        end
    end

    // R1
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_addr[ADDR_W-1:WIN_LSB] != base_q)) |-> !rf_sel);
    // R3
    base_move_chk: assert property (@(posedge clk) disable iff (rst)
        (base_q != $past(base_q)) |-> $past(hit && req_write && is_base));
    // R4
    empty_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_be_n == 4'hF) |=> ($stable(base_q) && $stable(cfga_q)));
    // R5
    full_word_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_sel && rf_write && kind == GRP_FULL) |-> rf_byte_en == 4'hF);
    // R10
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && hit) |=> rd_valid);
    // R10
    rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write && hit) |=> !rd_valid);

endmodule

// File: tb/regwin_decoder_bench.sv
module regwin_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [35:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be_n = 4'hF;
    logic        req_write = 1'b0;
    logic        req_src = 1'b0;
    logic        rd_valid, rf_sel, rf_write, rf_cfg, rf_src;
    logic [31:0] rd_data, rf_wdata, rf_rdata;
    logic [18:0] rf_offset;
    logic [3:0]  rf_byte_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // side-port model: distinct data per space and offset
    assign rf_rdata = {(rf_cfg ? 8'hC5 : 8'hD1), 5'd0, rf_offset};

    regwin_decoder u_regwin_decoder (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be_n(req_be_n), .req_write(req_write),
        .req_src(req_src), .rd_valid(rd_valid), .rd_data(rd_data),
        .rf_sel(rf_sel), .rf_write(rf_write), .rf_cfg(rf_cfg),
        .rf_offset(rf_offset), .rf_wdata(rf_wdata), .rf_byte_en(rf_byte_en),
        .rf_src(rf_src), .rf_rdata(rf_rdata)
    );

    logic        s_sel, s_cfg, s_src, s_rv;
    logic [3:0]  s_be;
    logic [18:0] s_off;
    logic [31:0] s_wd, s_rd;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic [35:0] a, input logic [31:0] d,
                          input logic [3:0] ben, input logic w, input logic s);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_wdata = d;
        req_be_n = ben; req_write = w; req_src = s;
        #1;
        s_sel = rf_sel; s_cfg = rf_cfg; s_off = rf_offset;
        s_be = rf_byte_en; s_wd = rf_wdata; s_src = rf_src;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        s_rv = rd_valid; s_rd = rd_data;
    endtask

    function automatic int grp_of(input int off);
        if (off >= 'h1000) return 0;
        if (off < 'hC00)  return 1;
        if (off < 'hD00)  return 2;
        if (off < 'hE00)  return 1;
        if (off < 'hF00)  return 2;
        return 0;
    endfunction

    function automatic logic [35:0] mk(input logic [14:0] b, input logic [20:0] o);
        return {b, o};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [14:0] base;
        base = 15'h0A0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("reset R10 rd_valid", 32'(rd_valid), 0);
        check("reset R1 rf_sel", 32'(rf_sel), 0);

        // R2 / R3 reset base readback and default location
        do_req(mk(base, 21'h068), 0, 4'h0, 1'b0, 1'b0);
        check("R3 base read", s_rd, 32'h0A0);
        check("R3 base not on side port", 32'(s_sel), 0);
        do_req(36'h14000800, 0, 4'h0, 1'b0, 1'b0);
        check("R2 default hit sel", 32'(s_sel), 1);
        check("R2 offset", 32'(s_off), 32'h200);
        check("R10 rd_valid", 32'(s_rv), 1);
        check("R2 R10 read data", s_rd, {8'hD1, 5'd0, 19'h200});
        @(negedge clk);
        check("R10 single pulse", 32'(rd_valid), 0);

        // R5 R6 R7 R11 sweep of offsets and byte enables
        for (int o = 0; o < 'h1000; o += 'h40) begin
            for (int b = 0; b < 16; b++) begin
                int g;
                logic [3:0] exp_be;
                g = grp_of(o);
                do_req(mk(base, 21'(o)), 32'hA5000000 + 32'(o), 4'(b), 1'b1, 1'(b & 1));
                exp_be = (g == 1) ? 4'hF : ~4'(b);
                if (g == 0 || b == 15) begin
                    check("R4 R7 no select", 32'(s_sel), 0);
                end else begin
                    check("R5 R6 select", 32'(s_sel), 1);
                    check(g == 1 ? "R5 full mask" : "R6 lane mask", 32'(s_be), 32'(exp_be));
                end
            end
            do_req(mk(base, 21'(o)), 0, 4'h0, 1'b0, 1'b1);
            check("R10 read valid", 32'(s_rv), 1);
            check("R7 R11 read data", s_rd,
                  grp_of(o) == 0 ? 32'h0 : {8'hD1, 5'd0, 19'(o >> 2)});
        end
        do_req(mk(base, 21'h1FFFFC), 0, 4'h0, 1'b0, 1'b0);
        check("R7 top unmapped sel", 32'(s_sel), 0);
        check("R7 top unmapped data", s_rd, 0);
        check("R10 unmapped read valid", 32'(s_rv), 1);

        // R11 passthrough
        do_req(mk(base, 21'h0ABC), 32'h1234_5678, 4'h0, 1'b1, 1'b1);
        check("R11 wdata", s_wd, 32'h1234_5678);
        check("R11 src", 32'(s_src), 1);
        check("R11 cfg flag", 32'(s_cfg), 0);
        check("R11 offset", 32'(s_off), 32'h2AF);

        // R1 flip each base bit
        for (int i = 21; i < 36; i++) begin
            logic [35:0] a;
            a = mk(base, 21'h800) ^ (36'd1 << i);
            do_req(a, 0, 4'h0, 1'b0, 1'b0);
            check("R1 miss sel", 32'(s_sel), 0);
            check("R1 miss rd_valid", 32'(s_rv), 0);
        end

        // R4 empty-lane write to base from bridge
        do_req(mk(base, 21'h068), 32'h0000_0055, 4'hF, 1'b1, 1'b1);
        do_req(mk(base, 21'h068), 0, 4'h0, 1'b0, 1'b0);
        check("R4 base unchanged", s_rd, 32'h0A0);

        // R3 relocate
        do_req(36'h14000068, 32'hFFFF_00BD, 4'h7, 1'b1, 1'b0);
        check("R3 base write off side port", 32'(s_sel), 0);
        base = 15'h0BD;
        do_req(36'h17A00800, 0, 4'h0, 1'b0, 1'b0);
        check("R3 new address hit", 32'(s_sel), 1);
        check("R3 new address data", s_rd, {8'hD1, 5'd0, 19'h200});
        do_req(36'h14000800, 0, 4'h0, 1'b0, 1'b0);
        check("R3 old address miss", 32'(s_rv), 0);
        do_req(36'h17A00068, 0, 4'h0, 1'b0, 1'b0);
        check("R3 base readback", s_rd, 32'h0BD);

        // R8 configuration address register
        do_req(mk(base, 21'hCF8), 0, 4'h0, 1'b0, 1'b0);
        check("R8 reset zero", s_rd, 0);
        do_req(mk(base, 21'hCF8), 32'h0000_0007, 4'h0, 1'b1, 1'b0);
        do_req(mk(base, 21'hCF8), 0, 4'h0, 1'b0, 1'b0);
        check("R8 low bits forced", s_rd, 32'h4);
        check("R8 not on side port", 32'(s_sel), 0);
        do_req(mk(base, 21'hCF8), 32'h0000_00F0, 4'h1, 1'b1, 1'b0);
        do_req(mk(base, 21'hCF8), 0, 4'h0, 1'b0, 1'b0);
        check("R8 disabled lane kept", s_rd, 32'h4);
        do_req(mk(base, 21'hCF8), 32'h0000_0033, 4'hE, 1'b1, 1'b0);
        do_req(mk(base, 21'hCF8), 0, 4'h0, 1'b0, 1'b0);
        check("R8 lane0 write", s_rd, 32'h30);

        // R9 data port
        do_req(mk(base, 21'hCF8), 32'h0000_0004, 4'h0, 1'b1, 1'b0);
        do_req(mk(base, 21'hCFC), 0, 4'h0, 1'b0, 1'b0);
        check("R9 cfg flag", 32'(s_cfg), 1);
        check("R9 cfg offset", 32'(s_off), 1);
        check("R9 read data", s_rd, {8'hC5, 5'd0, 19'h1});
        check("R9 R10 read valid", 32'(s_rv), 1);
        do_req(mk(base, 21'hCFC), 32'hDEAD_BEEF, 4'hA, 1'b1, 1'b0);
        check("R9 write sel", 32'(s_sel), 1);
        check("R9 write lanes", 32'(s_be), 32'h5);
        do_req(mk(base, 21'hCFC), 32'hDEAD_BEEF, 4'hF, 1'b1, 1'b1);
        check("R4 R9 empty write", 32'(s_sel), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule